// File: doc/BRIEF.md
# Video Stream Stability Monitor

This block decides whether a video stream has settled after the video path is switched on. A single-cycle start pulse opens a check. The block confirms the link PLL is locked at that moment. It then waits for the stream clock to appear. Last, it watches the stream-present flag until the flag holds long enough. The check ends in one of three results: stable, timeout or not ready.

Inputs are read only on sample ticks from an internal prescaler, one tick every `TICK_DIV` clocks. A typical setting gives about one sample per millisecond. The clock wait and the stream wait each have their own limit, counted in samples. The run length that counts as stable is also a parameter. A result stays on its output until the next start pulse.

Top module: `vstab_monitor`

## Requirements
- R1: If `pll_locked_i` is low when `start_i` is sampled high, `not_ready_o` goes high on the next clock edge and no sampling takes place.
- R2: In this requirement, sample k is the clock edge k*`TICK_DIV` clocks after the start edge. Sampling begins at sample 1. The block leaves the clock wait at the first sample where `stream_clk_ok_i` is high. If the clock status is still low at sample `CLK_WAIT_MAX`+1 of the clock wait, `timeout_o` rises at that edge.
- R3: During the stream wait, `stable_o` rises at the sample where `stream_on_i` has been high on `RUN_LEN`+1 consecutive samples.
- R4: A sample with `stream_on_i` low sets the consecutive count back to zero.
- R5: If the stream wait reaches its sample number `STRM_WAIT_MAX`+1 and the stream is not stable, `timeout_o` rises at that edge. Stream-wait samples are numbered from the sample after the clock was seen.
- R6: If the stable condition and the stream timeout fall on the same sample, the result is stable.
- R7: `stream_clk_ok_i` has no effect once the stream wait has begun.
- R8: After reset all three outputs are low. At most one of them is high at any time. A result holds unchanged until the next start pulse.
- R9: A start pulse at any time clears all outputs and restarts the check from sample 1, dropping any check in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Single-cycle pulse that begins a check |
| pll_locked_i | input | 1 | Link PLL lock status |
| stream_clk_ok_i | input | 1 | Stream clock present |
| stream_on_i | input | 1 | Stream-present status |
| stable_o | output | 1 | Stream declared stable |
| timeout_o | output | 1 | Clock or stream wait exceeded its limit |
| not_ready_o | output | 1 | PLL was unlocked at start |

## Verification
The hardest case to reach is a run of stream-on samples that completes on exactly the sample where the stream timeout also expires (R6). Reaching it means the clock must appear on a known sample, and the stream must stay off until the final `RUN_LEN`+1 samples of the window. The bench builds per-sample bit vectors for the clock and stream flags. A driver presents one vector entry per tick period. A reference model in the bench works out the expected result and the sample on which it appears. This lets the bench place an input pattern exactly on that shared edge, and also test clock-absent timeouts, dropouts one sample short of the run length, and an abort part way through a check.

// File: rtl/vstab_pkg.sv
package vstab_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_CLK_WAIT  = 2'd1,
    ST_STRM_WAIT = 2'd2,
    ST_DONE      = 2'd3
  } vstab_state_e;
endpackage

// File: rtl/vstab_tick_gen.sv
module vstab_tick_gen #(
  parameter int unsigned DIV = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (en_i)     cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);

  generate
    if (DIV > 1) begin : g_spacing
      a_r2_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/vstab_win_cnt.sv
module vstab_win_cnt #(
  parameter int unsigned MAX = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic inc_i,
  output logic over_o
);
  localparam int unsigned W = $clog2(MAX + 1);
  localparam logic [W-1:0] LIM = W'(MAX);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clear_i)                cnt_q <= '0;
    else if (inc_i && cnt_q != LIM)  cnt_q <= cnt_q + 1'b1;
  end

  // this sample is number MAX+1
  assign over_o = inc_i && (cnt_q == LIM);

  a_r5_win_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM);
endmodule

// File: rtl/vstab_run_cnt.sv
module vstab_run_cnt #(
  parameter int unsigned RUN_LEN = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic sample_i,
  input  logic on_i,
  output logic done_o
);
  localparam int unsigned W = $clog2(RUN_LEN + 1);
  localparam logic [W-1:0] LIM = W'(RUN_LEN);

  logic [W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_q <= '0;
    else if (clear_i)   run_q <= '0;
    else if (sample_i) begin
      if (!on_i)              run_q <= '0;
      else if (run_q != LIM)  run_q <= run_q + 1'b1;
    end
  end

  // RUN_LEN prior hits plus this one
  assign done_o = sample_i && on_i && (run_q == LIM);

  a_r4_dropout_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && !on_i && !clear_i) |=> (run_q == '0));
  a_r3_run_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= LIM);
endmodule

// File: rtl/vstab_ctrl.sv
module vstab_ctrl
  import vstab_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic pll_locked_i,
  input  logic clk_ok_i,
  input  logic tick_i,
  input  logic run_done_i,
  input  logic clk_over_i,
  input  logic strm_over_i,
  output logic clear_o,
  output logic tick_en_o,
  output logic clk_inc_o,
  output logic strm_inc_o,
  output logic stable_o,
  output logic timeout_o,
  output logic not_ready_o
);
  vstab_state_e state_q;

  assign clear_o    = start_i;
  assign tick_en_o  = (state_q == ST_CLK_WAIT) || (state_q == ST_STRM_WAIT);
  assign clk_inc_o  = tick_i && (state_q == ST_CLK_WAIT);
  assign strm_inc_o = tick_i && (state_q == ST_STRM_WAIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      stable_o    <= 1'b0;
      timeout_o   <= 1'b0;
      not_ready_o <= 1'b0;
    end else if (start_i) begin
      stable_o    <= 1'b0;
      timeout_o   <= 1'b0;
      not_ready_o <= !pll_locked_i;
      state_q     <= pll_locked_i ? ST_CLK_WAIT : ST_DONE;
    end else begin
      unique case (state_q)
        ST_CLK_WAIT: if (tick_i) begin
          if (clk_ok_i) state_q <= ST_STRM_WAIT;
          else if (clk_over_i) begin
            timeout_o <= 1'b1;
            state_q   <= ST_DONE;
          end
        end
        ST_STRM_WAIT: if (tick_i) begin
          // stable takes priority over a coincident timeout
          if (run_done_i) begin
            stable_o <= 1'b1;
            state_q  <= ST_DONE;
          end else if (strm_over_i) begin
            timeout_o <= 1'b1;
            state_q   <= ST_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  a_r1_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !pll_locked_i) |=> (not_ready_o && !stable_o && !timeout_o));
  a_r9_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && pll_locked_i) |=> (!stable_o && !timeout_o && !not_ready_o));
  a_r8_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({stable_o, timeout_o, not_ready_o}));
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE && !start_i) |=> $stable({stable_o, timeout_o, not_ready_o}));
  a_r6_stable_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strm_inc_o && run_done_i && !start_i) |=> (stable_o && !timeout_o));
endmodule

// File: rtl/vstab_monitor.sv
module vstab_monitor #(
  parameter int unsigned TICK_DIV      = 50000,
  parameter int unsigned RUN_LEN       = 10,
  parameter int unsigned CLK_WAIT_MAX  = 100,
  parameter int unsigned STRM_WAIT_MAX = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic pll_locked_i,
  input  logic stream_clk_ok_i,
  input  logic stream_on_i,
  output logic stable_o,
  output logic timeout_o,
  output logic not_ready_o
);
  logic clear, tick_en, tick, clk_inc, strm_inc;
  logic run_done, clk_over, strm_over;

  vstab_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear), .en_i(tick_en), .tick_o(tick)
  );

  vstab_win_cnt #(.MAX(CLK_WAIT_MAX)) u_clk_win (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear), .inc_i(clk_inc), .over_o(clk_over)
  );

  vstab_win_cnt #(.MAX(STRM_WAIT_MAX)) u_strm_win (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear), .inc_i(strm_inc), .over_o(strm_over)
  );

  vstab_run_cnt #(.RUN_LEN(RUN_LEN)) u_run (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear), .sample_i(strm_inc),
    .on_i(stream_on_i), .done_o(run_done)
  );

  vstab_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .pll_locked_i(pll_locked_i),
    .clk_ok_i(stream_clk_ok_i), .tick_i(tick), .run_done_i(run_done),
    .clk_over_i(clk_over), .strm_over_i(strm_over), .clear_o(clear),
    .tick_en_o(tick_en), .clk_inc_o(clk_inc), .strm_inc_o(strm_inc),
    .stable_o(stable_o), .timeout_o(timeout_o), .not_ready_o(not_ready_o)
  );
endmodule

// File: tb/vstab_monitor_tb_top.sv
module vstab_monitor_tb_top;
  localparam int D  = 4;
  localparam int RL = 10;
  localparam int CW = 6;
  localparam int SW = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, pll = 1'b0, ck_ok = 1'b0, s_on = 1'b0;
  logic stable, tmo, nrdy;

  always #10 clk = ~clk;

  vstab_monitor #(.TICK_DIV(D), .RUN_LEN(RL), .CLK_WAIT_MAX(CW), .STRM_WAIT_MAX(SW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pll_locked_i(pll),
    .stream_clk_ok_i(ck_ok), .stream_on_i(s_on),
    .stable_o(stable), .timeout_o(tmo), .not_ready_o(nrdy)
  );

  typedef struct { int kind; int at; string tag; } exp_t;
  exp_t q[$];
  int n_checks = 0, n_fail = 0, cyc = 0, c0 = 0;
  logic armed = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int out_kind();
    int k;
    k = 0;
    if (stable) k = 1;
    if (tmo)    k = (k == 0) ? 2 : 9;
    if (nrdy)   k = (k == 0) ? 3 : 9;
    return k;
  endfunction

  // reference: kind 1 stable, 2 timeout, 3 not ready; at = sample index
  function automatic void model(input logic p, input logic [63:0] ck, input logic [63:0] on,
                                output int kind, output int at);
    int n, run, ph;
    kind = 0; at = 0; n = 0; run = 0; ph = 0;
    if (!p) begin kind = 3; return; end
    for (int j = 1; j < 64; j++) begin
      n++;
      if (ph == 0) begin
        if (ck[j]) begin ph = 1; n = 0; end
        else if (n > CW) begin kind = 2; at = j; return; end
      end else begin
        if (on[j]) run++; else run = 0;
        if (run > RL) begin kind = 1; at = j; return; end
        else if (n > SW) begin kind = 2; at = j; return; end
      end
    end
  endfunction

  task automatic run_case(string tag, logic p, logic [63:0] ck, logic [63:0] on, int abort_after);
    exp_t e;
    int k, a;
    @(negedge clk);
    start = 1'b1; pll = p;
    @(negedge clk);
    start = 1'b0; c0 = cyc;
    if (abort_after == 0) begin
      model(p, ck, on, k, a);
      e.kind = k; e.at = a; e.tag = tag;
      q.push_back(e);
      armed = 1'b1;
    end
    #1;
    if (p) chk({tag, " R9 cleared at start"}, out_kind(), 0);
    for (int j = 1; j < 64; j++) begin
      if (abort_after == 0 && !armed) break;
      if (abort_after != 0 && j > abort_after) break;
      ck_ok = ck[j]; s_on = on[j];
      repeat (D) @(negedge clk);
    end
    if (abort_after != 0) begin
      #1 chk({tag, " R9 no result before restart"}, out_kind(), 0);
    end else begin
      while (armed) @(negedge clk);
      repeat (3 * D) @(negedge clk);
      ck_ok = ~ck_ok; s_on = ~s_on;
      repeat (2 * D) @(negedge clk);
      #1 chk({tag, " R8 result held"}, out_kind(), k);
    end
  endtask

  // monitor: compare first result after each start
  always begin
    exp_t e;
    @(negedge clk);
    #1;
    if (armed && (stable || tmo || nrdy)) begin
      e = q.pop_front();
      chk({e.tag, " result kind"}, out_kind(), e.kind);
      chk({e.tag, " result cycle"}, cyc - c0, e.at * D);
      armed = 1'b0;
    end
  end

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1 chk("R8 reset outputs low", out_kind(), 0);
    run_case("R1 pll unlocked", 1'b0, '1, '1, 0);
    run_case("R3 steady stream", 1'b1, '1, '1, 0);
    run_case("R2 clock never seen", 1'b0 | 1'b1, '0, '1, 0);
    run_case("R2 clock on last sample", 1'b1, 64'h1 << (CW + 1), '1, 0);
    run_case("R4 dropout one short", 1'b1, '1, ~(64'h1 << 11), 0);
    run_case("R5 stream toggling", 1'b1, '1, {32{2'b10}}, 0);
    run_case("R6 stable vs timeout tie", 1'b1, '1,
             ((64'h1 << 33) - 1) & ~((64'h1 << 22) - 1), 0);
    run_case("R7 clock drops in stream wait", 1'b1, 64'h2, '1, 0);
    run_case("R9 abort", 1'b1, '1, '1, 5);
    run_case("R9 restart after abort", 1'b1, '1, ~(64'h1 << 4), 0);
    run_case("R1 second unlocked", 1'b0, '1, '1, 0);
    chk("scoreboard drained", q.size(), 0);
    finish_up();
  end
endmodule